// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger Unit

This unit sits between the register decoder of a 16-entry UART and its FIFO storage. It takes byte writes aimed at the FIFO-control register and holds the settings they carry: the FIFO enable, a DMA-mode flag and a two-bit receive trigger select. A write can also ask for either FIFO to be flushed. The unit answers such a request with a single-cycle clear strobe toward the storage, and the request bits read back as zero.

From the receive occupancy supplied by the storage, the unit drives a trigger-reached flag for the interrupt logic. It also assembles the line-status byte from the FIFO counts, the head-entry error flags, the transmitter busy signal and the overrun flag. It keeps its own count of the erroneous entries still held in the receive FIFO, which feeds the summary error bit. The identification-register readback bits that report FIFO mode also come from here.

Top module: `uart_fifo_ctl`

## Requirements
- R1: Bit 0 of a control write sets `fifo_en` from the next cycle on. `id_fifo_bits` reads 2'b11 while enabled and 2'b00 otherwise. Without a write, `fifo_en` keeps its value.
- R2: Bit 1 of a control write raises `rx_clr` for exactly the one cycle after the write. Bit 2 does the same for `tx_clr`. A clear request for one FIFO does not pulse the other.
- R3: A write that changes the enable bit, in either direction, pulses both `rx_clr` and `tx_clr` in the following cycle, whatever bits 1 and 2 hold.
- R4: With FIFOs enabled, bits [7:6] select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 entries. `trig_hit` is high exactly when `rx_count` is at or above the selected level.
- R5: With FIFOs disabled, `trig_hit` is high whenever `rx_count` is nonzero, regardless of the stored select.
- R6: Bit 3 is stored and read on `dma_mode`. It has no effect on `trig_hit`.
- R7: `fcr_view` returns {select[1:0], 2'b00, dma, 2'b00, enable}. The clear bits 1 and 2 and the reserved bits 4 and 5 always read 0.
- R8: Line-status bit 0 (data ready) is `rx_count != 0`. Bit 5 (holding empty) is `tx_count == 0`. Bit 6 (transmitter idle) is `tx_count == 0` with `tx_busy` low.
- R9: Line-status bit 7 is high while at least one error-flagged entry remains in the receive FIFO. That count rises on `rx_push_err` and falls on `rx_pop_err`, and it counts only while enabled. An `rx_clr` pulse empties it in the cycle after the pulse. Bit 7 reads 0 while FIFOs are disabled.
- R10: Line-status bit 1 follows `overrun`. Bits 2, 3 and 4 show `head_pe`, `head_fe` and `head_bi` only while `rx_count` is nonzero, and read 0 otherwise.
- R11: After reset, FIFOs are disabled, the select is 00, DMA mode is off, no clear strobe is high and `fcr_view` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the FIFO-control register |
| wr_data | input | 8 | Write data |
| rx_count | input | 5 | Receive FIFO occupancy |
| tx_count | input | 5 | Transmit FIFO occupancy |
| tx_busy | input | 1 | Transmit shifter is sending |
| rx_push_err | input | 1 | An error-flagged entry is written into the receive FIFO |
| rx_pop_err | input | 1 | An error-flagged entry is read out of the receive FIFO |
| overrun | input | 1 | Overrun flag from the receive engine |
| head_pe | input | 1 | Parity error on the head receive entry |
| head_fe | input | 1 | Framing error on the head receive entry |
| head_bi | input | 1 | Break on the head receive entry |
| fifo_en | output | 1 | FIFO mode enabled |
| dma_mode | output | 1 | Stored DMA-mode flag |
| rx_clr | output | 1 | One-cycle receive FIFO clear |
| tx_clr | output | 1 | One-cycle transmit FIFO clear |
| trig_hit | output | 1 | Receive trigger level reached |
| fcr_view | output | 8 | Readback of stored control bits |
| id_fifo_bits | output | 2 | FIFO-mode bits for the identification register |
| lsr | output | 8 | Line-status byte |

## Verification
The hardest state to reach is the summary error bit around a flush. Error-flagged entries must be pushed while enabled, and a receive clear must then be requested while the count is nonzero. The bit has to stay high during the strobe cycle and drop one cycle later. The bench builds this up with push and pop strobes, steps the count up to two and back to zero, and then issues the flush with one error entry still held. It also sweeps `rx_count` from 0 to 16 under each trigger select, with DMA mode both off and on, so that every threshold edge is exercised.

// File: rtl/uart_fctl_pkg.sv
package uart_fctl_pkg;

  typedef enum logic [1:0] {
    TRG_ONE      = 2'd0,
    TRG_QUARTER  = 2'd1,
    TRG_HALF     = 2'd2,
    TRG_NEARFULL = 2'd3
  } trig_sel_e;

  // line-status bit positions (software decodes these)
  localparam int LSR_DR   = 0;
  localparam int LSR_OVR  = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_HOLD = 5;
  localparam int LSR_IDLE = 6;
  localparam int LSR_ERRS = 7;

  // receive threshold in entries for a given select and FIFO depth
  function automatic int trig_level(trig_sel_e sel, int depth);
    case (sel)
      TRG_ONE:     return 1;
      TRG_QUARTER: return depth / 4;
      TRG_HALF:    return depth / 2;
      default:     return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/fctl_reg.sv
module fctl_reg
  import uart_fctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [7:0] wr_data,
  output logic      fifo_en,
  output logic      dma_mode,
  output trig_sel_e trig_sel,
  output logic      rx_clr,
  output logic      tx_clr,
  output logic      en_toggle
);

  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[5:4];

  // write that flips the enable state
  assign en_toggle = wr_en && (wr_data[0] != fifo_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      trig_sel <= TRG_ONE;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
      if (wr_en) begin
        fifo_en  <= wr_data[0];
        dma_mode <= wr_data[3];
        trig_sel <= trig_sel_e'(wr_data[7:6]);
        rx_clr   <= wr_data[1] | en_toggle;
        tx_clr   <= wr_data[2] | en_toggle;
      end
    end
  end

  a_r1_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fifo_en));

  a_r2_rx_clr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> $past(wr_en));

  a_r2_tx_clr_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |-> $past(wr_en));

  a_r3_toggle_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[0] != fifo_en)) |=> (rx_clr && tx_clr));

endmodule

// File: rtl/fctl_trig.sv
module fctl_trig
  import uart_fctl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  trig_sel_e     trig_sel,
  input  logic [CW-1:0] rx_count,
  output logic          trig_hit
);

  int level;
  assign level = trig_level(trig_sel, DEPTH);

  always_comb begin
    if (fifo_en) trig_hit = int'(rx_count) >= level;
    else         trig_hit = (rx_count != '0);
  end

  a_r5_disabled_any_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_count != '0) |-> trig_hit);

  a_r4_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |-> !trig_hit);

  a_r4_full_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_count) >= DEPTH) |-> trig_hit);

endmodule

// File: rtl/fctl_lsr.sv
module fctl_lsr
  import uart_fctl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_clr,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_busy,
  input  logic          rx_push_err,
  input  logic          rx_pop_err,
  input  logic          overrun,
  input  logic          head_pe,
  input  logic          head_fe,
  input  logic          head_bi,
  output logic [7:0]    lsr
);

  logic [CW-1:0] err_cnt, err_nxt;
  logic          data_ready;

  assign data_ready = (rx_count != '0);

  always_comb begin
    err_nxt = err_cnt;
    if (fifo_en) begin
      if (rx_push_err && !rx_pop_err && err_cnt != CW'(DEPTH))
        err_nxt = err_cnt + 1'b1;
      else if (rx_pop_err && !rx_push_err && err_cnt != '0)
        err_nxt = err_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_cnt <= '0;
    else if (rx_clr) err_cnt <= '0;
    else             err_cnt <= err_nxt;
  end

  always_comb begin
    lsr           = '0;
    lsr[LSR_DR]   = data_ready;
    lsr[LSR_OVR]  = overrun;
    lsr[LSR_PE]   = data_ready && head_pe;
    lsr[LSR_FE]   = data_ready && head_fe;
    lsr[LSR_BI]   = data_ready && head_bi;
    lsr[LSR_HOLD] = (tx_count == '0);
    lsr[LSR_IDLE] = (tx_count == '0) && !tx_busy;
    lsr[LSR_ERRS] = fifo_en && (err_cnt != '0);
  end

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= CW'(DEPTH));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (err_cnt == '0));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !lsr[LSR_ERRS]);

  a_r10_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> (lsr[4:2] == 3'b000));

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fctl_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_busy,
  input  logic          rx_push_err,
  input  logic          rx_pop_err,
  input  logic          overrun,
  input  logic          head_pe,
  input  logic          head_fe,
  input  logic          head_bi,
  output logic          fifo_en,
  output logic          dma_mode,
  output logic          rx_clr,
  output logic          tx_clr,
  output logic          trig_hit,
  output logic [7:0]    fcr_view,
  output logic [1:0]    id_fifo_bits,
  output logic [7:0]    lsr
);

  trig_sel_e trig_sel;
  logic      en_toggle;
  logic      unused_toggle;

  assign unused_toggle = en_toggle;

  fctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .trig_sel (trig_sel),
    .rx_clr   (rx_clr),
    .tx_clr   (tx_clr),
    .en_toggle(en_toggle)
  );

  fctl_trig #(.DEPTH(DEPTH)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .trig_sel(trig_sel),
    .rx_count(rx_count),
    .trig_hit(trig_hit)
  );

  fctl_lsr #(.DEPTH(DEPTH)) u_lsr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .rx_clr     (rx_clr),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .tx_busy    (tx_busy),
    .rx_push_err(rx_push_err),
    .rx_pop_err (rx_pop_err),
    .overrun    (overrun),
    .head_pe    (head_pe),
    .head_fe    (head_fe),
    .head_bi    (head_bi),
    .lsr        (lsr)
  );

  assign fcr_view     = {trig_sel, 2'b00, dma_mode, 2'b00, fifo_en};
  assign id_fifo_bits = {2{fifo_en}};

  a_r7_clear_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_view[2:1] == 2'b00);

  a_r1_id_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_en) |-> (id_fifo_bits == 2'b11));

endmodule

// File: tb/tb_uart_fifo_ctl.sv
module tb_uart_fifo_ctl;

  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [CW-1:0] rx_count = '0;
  logic [CW-1:0] tx_count = '0;
  logic tx_busy = 1'b0, rx_push_err = 1'b0, rx_pop_err = 1'b0;
  logic overrun = 1'b0, head_pe = 1'b0, head_fe = 1'b0, head_bi = 1'b0;
  logic fifo_en, dma_mode, rx_clr, tx_clr, trig_hit;
  logic [7:0] fcr_view, lsr;
  logic [1:0] id_fifo_bits;

  always #2 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rx_count(rx_count), .tx_count(tx_count), .tx_busy(tx_busy),
    .rx_push_err(rx_push_err), .rx_pop_err(rx_pop_err), .overrun(overrun),
    .head_pe(head_pe), .head_fe(head_fe), .head_bi(head_bi),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .trig_hit(trig_hit), .fcr_view(fcr_view), .id_fifo_bits(id_fifo_bits),
    .lsr(lsr)
  );

  // observable selectors
  localparam int S_EN = 0, S_RXC = 1, S_TXC = 2, S_HIT = 3, S_FCR = 4,
                 S_ID = 5, S_DMA = 6, S_LSR0 = 10;

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic int observe(int sel);
    if (sel >= S_LSR0) return int'(lsr[sel - S_LSR0]);
    case (sel)
      S_EN:  return int'(fifo_en);
      S_RXC: return int'(rx_clr);
      S_TXC: return int'(tx_clr);
      S_HIT: return int'(trig_hit);
      S_FCR: return int'(fcr_view);
      S_ID:  return int'(id_fifo_bits);
      S_DMA: return int'(dma_mode);
      default: return -1;
    endcase
  endfunction

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_v(string req, int sel, int exp);
    q.push_back('{req, sel, exp});
  endtask

  task automatic fcr_write(logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic int ref_level(int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    if (sel == 2) return 8;
    return 14;
  endfunction

  task automatic sweep(int sel, logic dma);
    fcr_write({sel[1:0], 2'b00, dma, 3'b001});
    tick();
    for (int c = 0; c <= DEPTH; c++) begin
      rx_count = CW'(c);
      expect_v(dma ? "R6" : "R4", S_HIT, (c >= ref_level(sel)) ? 1 : 0);
      tick();
    end
    rx_count = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11 reset state
    expect_v("R11", S_EN, 0);
    expect_v("R11", S_RXC, 0);
    expect_v("R11", S_TXC, 0);
    expect_v("R11", S_FCR, 0);
    expect_v("R11", S_DMA, 0);
    expect_v("R1", S_ID, 0);
    rst_n = 1'b1;
    tick();

    // enable: R1 and R3
    fcr_write(8'h01);
    expect_v("R1", S_EN, 1);
    expect_v("R1", S_ID, 3);
    expect_v("R3", S_RXC, 1);
    expect_v("R3", S_TXC, 1);
    tick();
    expect_v("R2", S_RXC, 0);
    expect_v("R2", S_TXC, 0);
    expect_v("R1", S_EN, 1);
    tick();

    // receive-only clear R2
    fcr_write(8'h03);
    expect_v("R2", S_RXC, 1);
    expect_v("R2", S_TXC, 0);
    tick();
    expect_v("R2", S_RXC, 0);
    tick();
    // transmit-only clear R2
    fcr_write(8'h05);
    expect_v("R2", S_RXC, 0);
    expect_v("R2", S_TXC, 1);
    tick();
    expect_v("R2", S_TXC, 0);
    tick();

    // readback R7, dma R6
    fcr_write(8'hCF);
    expect_v("R7", S_FCR, 8'hC9);
    expect_v("R6", S_DMA, 1);
    tick();
    fcr_write(8'h77);
    expect_v("R7", S_FCR, 8'h41);
    expect_v("R6", S_DMA, 0);
    tick();

    // trigger sweeps R4, R6
    for (int s = 0; s < 4; s++) sweep(s, 1'b0);
    for (int s = 0; s < 4; s++) sweep(s, 1'b1);

    // disable: R3 and R5
    fcr_write(8'hC0);
    expect_v("R1", S_EN, 0);
    expect_v("R1", S_ID, 0);
    expect_v("R3", S_RXC, 1);
    expect_v("R3", S_TXC, 1);
    tick();
    rx_count = '0;
    expect_v("R5", S_HIT, 0);
    tick();
    rx_count = 5'd1;
    expect_v("R5", S_HIT, 1);
    tick();
    rx_count = 5'd9;
    expect_v("R5", S_HIT, 1);
    tick();

    // line status R8
    rx_count = '0; tx_count = '0; tx_busy = 1'b0;
    expect_v("R8", S_LSR0 + 0, 0);
    expect_v("R8", S_LSR0 + 5, 1);
    expect_v("R8", S_LSR0 + 6, 1);
    tick();
    tx_busy = 1'b1;
    expect_v("R8", S_LSR0 + 5, 1);
    expect_v("R8", S_LSR0 + 6, 0);
    tick();
    tx_count = 5'd3; tx_busy = 1'b0; rx_count = 5'd2;
    expect_v("R8", S_LSR0 + 0, 1);
    expect_v("R8", S_LSR0 + 5, 0);
    expect_v("R8", S_LSR0 + 6, 0);
    tick();
    tx_count = '0;

    // R10 overrun and head flags
    overrun = 1'b1; head_pe = 1'b1; head_fe = 1'b1; head_bi = 1'b1; rx_count = '0;
    expect_v("R10", S_LSR0 + 1, 1);
    expect_v("R10", S_LSR0 + 2, 0);
    expect_v("R10", S_LSR0 + 3, 0);
    expect_v("R10", S_LSR0 + 4, 0);
    tick();
    rx_count = 5'd1; overrun = 1'b0; head_fe = 1'b0;
    expect_v("R10", S_LSR0 + 1, 0);
    expect_v("R10", S_LSR0 + 2, 1);
    expect_v("R10", S_LSR0 + 3, 0);
    expect_v("R10", S_LSR0 + 4, 1);
    tick();
    head_pe = 1'b0; head_bi = 1'b0;

    // R9 error count while disabled is ignored
    rx_push_err = 1'b1;
    tick();
    rx_push_err = 1'b0;
    expect_v("R9", S_LSR0 + 7, 0);
    tick();

    // R9 enabled: push, push, pop, pop
    fcr_write(8'h01);
    tick();
    expect_v("R9", S_LSR0 + 7, 0);
    rx_push_err = 1'b1;
    tick();
    rx_push_err = 1'b0;
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    rx_push_err = 1'b1;
    tick();
    rx_push_err = 1'b0;
    rx_pop_err = 1'b1;
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    rx_pop_err = 1'b0;
    expect_v("R9", S_LSR0 + 7, 0);
    tick();

    // R9 flush while an error entry is held
    rx_push_err = 1'b1;
    tick();
    rx_push_err = 1'b0;
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    fcr_write(8'h03);
    expect_v("R9", S_RXC, 1);
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    expect_v("R9", S_LSR0 + 7, 0);
    tick();

    // R9 disable gates bit 7
    rx_push_err = 1'b1;
    tick();
    rx_push_err = 1'b0;
    expect_v("R9", S_LSR0 + 7, 1);
    tick();
    fcr_write(8'h00);
    expect_v("R9", S_LSR0 + 7, 0);
    tick();
    tick();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule